// File: doc/BRIEF.md
# Maskable Interrupt Aggregator

This block gathers eight interrupt sources into one sticky status vector and reduces it to a single interrupt line. Seven sources come in as single-cycle event pulses. The eighth is a level from an external core, and only its rising edge is captured. Software reaches the block through three write strobes that share one data bus. One strobe loads the enable mask. One forces status bits to 1, which serves as a software trigger. One clears status bits for each data bit written as 1.

The status read word holds the eight sticky bits in its low byte. Bit 31 shows the registered live level of the core line, and the bits between read as zero. The interrupt output is registered. It goes high one cycle after any enabled status bit is set.

Top module: `irq_aggregator`

## Requirements
- R1: Status bit positions are fixed: 0 core, 1 hot-plug rise, 2 hot-plug fall, 3 nonce refresh, 4 random-number error, 5 bus timeout, 6 sense rise, 7 sense fall. Event input `src_evt[k]` feeds status bit k for k = 1..7.
- R2: A cycle with `mask_we` high loads `wdata` into the mask. The mask appears on `mask_q` after that edge. A mask bit of 1 enables its source, and the mask resets to zero.
- R3: A cycle with `set_we` high forces to 1 every status bit whose `wdata` bit is 1. The bit is visible on `stat_rd` after that edge, and bits with a 0 in `wdata` are unchanged.
- R4: A cycle with `clr_we` high clears every status bit whose `wdata` bit is 1, unless that bit is being set in the same cycle. Bits with a 0 in `wdata` are unchanged.
- R5: Status bit 0 is set by a rising edge of `core_lvl` and not by its level. After that bit is cleared, a level that stays high does not set it again.
- R6: `stat_rd[31]` equals `core_lvl` delayed by one clock, and `stat_rd[30:8]` always reads 0.
- R7: `irq_o` is 1 exactly when, one cycle earlier, some status bit was 1 with its mask bit also 1.
- R8: If a hardware event or a software set meets a clear on the same bit in the same cycle, the bit ends the cycle set.
- R9: Status bits reset to 0 and stay set after their event pulse ends, until they are cleared.
- R10: A one-cycle pulse on any `src_evt` bit sets its status bit on that clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| core_lvl | input | 1 | Level interrupt from the external core |
| src_evt | input | 7 | Event pulses for status bits 7..1 |
| mask_we | input | 1 | Mask load strobe |
| set_we | input | 1 | Status force strobe |
| clr_we | input | 1 | Status clear strobe |
| wdata | input | 8 | Write data shared by the three strobes |
| mask_q | output | 8 | Current mask |
| stat_rd | output | 32 | Status read word |
| irq_o | output | 1 | Registered interrupt output |

## Verification
A clear strobe can fall in the same cycle as a hardware event pulse or a software set aimed at the same bit. The bench sets every status bit, then in one cycle raises `clr_we` with all data bits at 1 while it pulses one event input. It expects only that event's bit to survive. A second case does the same with a rising edge on the core level against a clear of bit 0.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int SRC_N    = 8;
  localparam int STAT_W   = 32;
  localparam int LIVE_BIT = STAT_W - 1;
  localparam int PAD_W    = STAT_W - 1 - SRC_N;
  localparam int IDX_CORE = 0;
  localparam int IDX_HP_R = 1;
  localparam int IDX_HP_F = 2;
  localparam int IDX_NONC = 3;
  localparam int IDX_RNG  = 4;
  localparam int IDX_TOUT = 5;
  localparam int IDX_SN_R = 6;
  localparam int IDX_SN_F = 7;
endpackage

// File: rtl/irq_core_edge.sv
module irq_core_edge (
  input  logic clk,
  input  logic rst,
  input  logic lvl,
  output logic rise,
  output logic lvl_q
);
  always_ff @(posedge clk) begin
    if (rst) lvl_q <= 1'b0;
    else     lvl_q <= lvl;
  end

  assign rise = lvl & ~lvl_q;

  AST_RISE_NOT_TWICE: assert property (@(posedge clk) disable iff (rst)
    rise |=> !rise) else $error("rise detected on consecutive cycles"); // R5
  AST_LIVE_DELAY: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (lvl_q == $past(lvl))) else $error("live level not delayed by one"); // R6
endmodule

// File: rtl/irq_sticky_bank.sv
module irq_sticky_bank #(
  parameter int N = irq_agg_pkg::SRC_N
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] hw_set,
  input  logic         set_we,
  input  logic         clr_we,
  input  logic [N-1:0] wdata,
  output logic [N-1:0] stat_q
);
  logic [N-1:0] set_vec;
  logic [N-1:0] clr_vec;

  assign set_vec = hw_set | ({N{set_we}} & wdata);
  assign clr_vec = {N{clr_we}} & wdata;

  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)             stat_q[i] <= 1'b0;
      else if (set_vec[i]) stat_q[i] <= 1'b1;
      else if (clr_vec[i]) stat_q[i] <= 1'b0;
    end
  end

  AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    (set_vec != '0) |=> ((stat_q & $past(set_vec)) == $past(set_vec)))
    else $error("set bit not held"); // R8
  AST_STICKY: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((~stat_q & $past(stat_q) & ~$past(clr_vec)) == '0))
    else $error("status fell without clear"); // R9
  AST_CLR_TAKES: assert property (@(posedge clk) disable iff (rst)
    (clr_vec != '0) |=> ((stat_q & $past(clr_vec) & ~$past(set_vec)) == '0))
    else $error("clear ignored"); // R4
endmodule

// File: rtl/irq_line_gen.sv
module irq_line_gen #(
  parameter int N = irq_agg_pkg::SRC_N
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         mask_we,
  input  logic [N-1:0] wdata,
  input  logic [N-1:0] stat,
  output logic [N-1:0] mask_q,
  output logic         irq_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      if (mask_we) mask_q <= wdata;
      irq_q <= |(stat & mask_q);
    end
  end

  AST_IRQ_NEEDS_MASK: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> ($past(mask_q) != '0)) else $error("irq with empty mask"); // R7
  AST_MASK_LOAD: assert property (@(posedge clk) disable iff (rst)
    mask_we |=> (mask_q == $past(wdata))) else $error("mask not loaded"); // R2
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
  import irq_agg_pkg::*;
#(
  parameter int N = SRC_N
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              core_lvl,
  input  logic [N-1:1]      src_evt,
  input  logic              mask_we,
  input  logic              set_we,
  input  logic              clr_we,
  input  logic [N-1:0]      wdata,
  output logic [N-1:0]      mask_q,
  output logic [STAT_W-1:0] stat_rd,
  output logic              irq_o
);
  localparam int PAD = STAT_W - 1 - N;

  logic         core_rise;
  logic         core_live;
  logic [N-1:0] stat_q;
  logic [N-1:0] hw_set;

  irq_core_edge u_edge (
    .clk  (clk),
    .rst  (rst),
    .lvl  (core_lvl),
    .rise (core_rise),
    .lvl_q(core_live)
  );

  assign hw_set = {src_evt, core_rise};

  irq_sticky_bank #(.N(N)) u_bank (
    .clk   (clk),
    .rst   (rst),
    .hw_set(hw_set),
    .set_we(set_we),
    .clr_we(clr_we),
    .wdata (wdata),
    .stat_q(stat_q)
  );

  irq_line_gen #(.N(N)) u_line (
    .clk    (clk),
    .rst    (rst),
    .mask_we(mask_we),
    .wdata  (wdata),
    .stat   (stat_q),
    .mask_q (mask_q),
    .irq_q  (irq_o)
  );

  assign stat_rd = {core_live, {PAD{1'b0}}, stat_q};

  AST_CORE_RISE_SETS: assert property (@(posedge clk) disable iff (rst)
    (core_lvl && !stat_rd[LIVE_BIT]) |=> stat_rd[IDX_CORE])
    else $error("core edge lost"); // R5
endmodule

// File: tb/irq_aggregator_test.sv
`timescale 1ns/1ps
module irq_aggregator_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        core_lvl = 1'b0;
  logic [7:1]  src_evt = '0;
  logic        mask_we = 1'b0, set_we = 1'b0, clr_we = 1'b0;
  logic [7:0]  wdata = '0;
  logic [7:0]  mask_q;
  logic [31:0] stat_rd;
  logic        irq_o;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  irq_aggregator uut (
    .clk(clk), .rst(rst), .core_lvl(core_lvl), .src_evt(src_evt),
    .mask_we(mask_we), .set_we(set_we), .clr_we(clr_we), .wdata(wdata),
    .mask_q(mask_q), .stat_rd(stat_rd), .irq_o(irq_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_mask(input logic [7:0] v);
    mask_we = 1'b1; wdata = v; step(1); mask_we = 1'b0; wdata = '0;
  endtask
  task automatic wr_set(input logic [7:0] v);
    set_we = 1'b1; wdata = v; step(1); set_we = 1'b0; wdata = '0;
  endtask
  task automatic wr_clr(input logic [7:0] v);
    clr_we = 1'b1; wdata = v; step(1); clr_we = 1'b0; wdata = '0;
  endtask

  task automatic t_reset;
    rst = 1'b1; step(3);
    chk("R9 status after reset", stat_rd, 32'h0);
    chk("R2 mask after reset", {24'h0, mask_q}, 32'h0);
    chk("R7 irq after reset", {31'h0, irq_o}, 32'h0);
    rst = 1'b0; step(1);
  endtask

  task automatic t_mask;
    wr_mask(8'hA5);
    chk("R2 mask load", {24'h0, mask_q}, 32'hA5);
    step(1);
    chk("R7 no irq with empty status", {31'h0, irq_o}, 32'h0);
  endtask

  task automatic t_swset;
    wr_set(8'h18);
    chk("R3 software set", stat_rd, 32'h18);
    step(1);
    chk("R7 set bits masked off", {31'h0, irq_o}, 32'h0);
    wr_mask(8'h08);
    chk("R7 irq lags mask by one", {31'h0, irq_o}, 32'h0);
    step(1);
    chk("R7 irq after enable", {31'h0, irq_o}, 32'h1);
  endtask

  task automatic t_clear;
    wr_clr(8'h10);
    chk("R4 partial clear", stat_rd, 32'h08);
    wr_clr(8'h08);
    chk("R4 clear last bit", stat_rd, 32'h0);
    step(1);
    chk("R7 irq drops", {31'h0, irq_o}, 32'h0);
  endtask

  task automatic t_hw;
    for (int k = 1; k < 8; k++) begin
      src_evt = '0; src_evt[k] = 1'b1; step(1); src_evt = '0;
      chk($sformatf("R10 R1 event %0d sets its bit", k), stat_rd, 32'h1 << k);
      step(2);
      chk($sformatf("R9 event %0d bit sticky", k), stat_rd, 32'h1 << k);
      wr_clr(8'hFF);
    end
  endtask

  task automatic t_core;
    core_lvl = 1'b1; step(1);
    chk("R5 R6 core edge and live bit", stat_rd, 32'h8000_0001);
    wr_clr(8'h01);
    step(3);
    chk("R5 held level does not re-set", stat_rd, 32'h8000_0000);
    core_lvl = 1'b0; step(1);
    chk("R6 live bit follows low", stat_rd, 32'h0);
    core_lvl = 1'b1; step(1);
    chk("R5 second edge", stat_rd, 32'h8000_0001);
    core_lvl = 1'b0; wr_clr(8'h01);
    chk("R6 pad bits zero", stat_rd, 32'h0);
  endtask

  task automatic t_collision;
    wr_set(8'hFF);
    clr_we = 1'b1; wdata = 8'hFF; src_evt = 7'b0000100;
    step(1);
    clr_we = 1'b0; wdata = '0; src_evt = '0;
    chk("R8 event beats clear", stat_rd, 32'h08);
    wr_clr(8'hFF);
    clr_we = 1'b1; wdata = 8'h01; core_lvl = 1'b1;
    step(1);
    clr_we = 1'b0; wdata = '0;
    chk("R8 core edge beats clear", stat_rd, 32'h8000_0001);
    core_lvl = 1'b0; wr_clr(8'hFF);
    chk("R4 all cleared", stat_rd, 32'h0);
  endtask

  task automatic t_gate;
    wr_mask(8'h00);
    wr_set(8'hFF);
    step(2);
    chk("R7 full status, zero mask", {31'h0, irq_o}, 32'h0);
    wr_mask(8'h80);
    step(1);
    chk("R7 top bit enabled", {31'h0, irq_o}, 32'h1);
    wr_clr(8'h80);
    step(1);
    chk("R7 enabled bit cleared", {31'h0, irq_o}, 32'h0);
  endtask

  initial begin
    step(1);
    t_reset;
    t_mask;
    t_swset;
    t_clear;
    t_hw;
    t_core;
    t_collision;
    t_gate;
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule